// File: doc/BRIEF.md
# Fade-Out Gain Ramp Controller

This block owns the gain code of a programmable input gain stage and walks it down to mute when software raises a fade-out control bit. The descent is split into a fixed number of equal timing windows counted in sample strobes. Each window carries one gain step. The step lands on the first zero crossing of the audio stream inside the window, or on the window's last strobe if no crossing comes. Because the window count is fixed, the whole fade always takes the same number of samples. This holds even when a limiter request takes extra gain away during the fade.

The same window machinery also runs a fade-in back up toward a preset gain. A host write port loads that preset. When the level-control enable is set, dropping the fade-out bit restores the preset. Dropping the fade-out bit and the level-control enable together freezes the gain where it is. A fade-out request always beats a fade-in request.

Top module: `fade_gain_ramp`

## Requirements
- R1: After synchronous reset, `gain` is 0 (the mute code) and the block is idle.
- R2: A host write while idle loads both `gain` and the preset. While a fade is running or the gain is parked at mute, a host write loads only the preset and leaves `gain` unchanged.
- R3: A 0-to-1 change of `ctl_fade_out` starts a fade-out. Window length is P = PER_BASE << `ctl_period` strobes, with PER_BASE = 4 by default. The step is 1 << `ctl_step`. Both fields are captured at the start of the fade. Each window lowers `gain` by exactly one step, saturating at 0.
- R4: A zero crossing is a strobe whose sample is zero, or whose sign bit differs from the sign bit of the previous strobe's sample. The window's step is applied at its first zero crossing. If the window has none, the step is applied on its last strobe. No window applies more than one step.
- R5: After (96 >> `ctl_step`) windows, which is 96·P/step strobes from the start, `gain` becomes 0. It is never forced to 0 before that strobe.
- R6: Once muted, `gain` stays 0 for as long as `ctl_fade_out` stays 1, whatever the samples do.
- R7: A `lim_req` pulse while `ctl_lvl_en` = 1 lowers `gain` by 1 at the next zero crossing that carries no fade step. It does not change the window count or the strobe on which mute is reached.
- R8: A 1-to-0 change of `ctl_fade_out` during or after a fade, with `ctl_lvl_en` = 1, loads the preset into `gain` and returns the block to idle.
- R9: If `ctl_fade_out` falls while `ctl_lvl_en` is 0, including when both fall on the same write, the fade stops and `gain` holds its value.
- R10: A 0-to-1 change of `ctl_fade_in` while idle and with `ctl_fade_out` = 0 raises `gain` by one step per window, capped at the preset. After (96 >> `ctl_step`) windows, `gain` equals the preset.
- R11: If `ctl_fade_in` and `ctl_fade_out` rise together, or `ctl_fade_out` rises during a fade-in, the block runs a fade-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_fade_out | input | 1 | Fade-out request level; a rising edge starts a fade |
| ctl_fade_in | input | 1 | Fade-in request level; a rising edge starts a fade-in |
| ctl_lvl_en | input | 1 | Level-control enable |
| ctl_period | input | 2 | Window length select, P = PER_BASE << value |
| ctl_step | input | 2 | Step size select, step = 1 << value |
| smp_valid | input | 1 | Sample strobe, also the timing tick |
| smp_data | input | SMP_W | Signed audio sample |
| lim_req | input | 1 | Limiter gain-reduction request pulse |
| host_we | input | 1 | Host gain write strobe |
| host_gain | input | GAIN_W | Host gain value |
| gain | output | GAIN_W | Current gain code, registered |

## Verification
The assertions assume the control bits change as register levels, held for at least one clock. They also assume that a fade start never shares a clock with a sample strobe, so the first window always gets its full count. The bench changes control bits only on clocks with no strobe, and it separates strobes with idle clocks. Its random part varies the starting gain and both select fields, and it feeds samples of constant sign so that every step lands on a window boundary the bench can predict. Zero-crossing placement and limiter timing are driven only by directed sequences with known sign patterns.

// File: rtl/fgr_pkg.sv
package fgr_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_OUT  = 2'd1,
    M_MUTE = 2'd2,
    M_IN   = 2'd3
  } fgr_mode_t;
endpackage

// File: rtl/fgr_zero_cross.sv
module fgr_zero_cross #(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [SMP_W-1:0] sample,
  output logic             zc
);
  logic prev_neg_q;

  // crossing: sign flip against the previous strobe, or an exact zero
  assign zc = valid & ((sample[SMP_W-1] != prev_neg_q) | (sample == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_neg_q <= 1'b0;
    end else if (valid) begin
      prev_neg_q <= sample[SMP_W-1];
    end
  end
endmodule

// File: rtl/fgr_step_timer.sv
module fgr_step_timer #(
  parameter int PER_W  = 6,
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              tick,
  input  logic [PER_W-1:0]  period,
  input  logic [SLOT_W-1:0] slots,
  output logic              win_end,
  output logic              last_win,
  output logic              running
);
  logic [PER_W-1:0]  cnt_q;
  logic [PER_W-1:0]  per_q;
  logic [SLOT_W-1:0] left_q;
  logic              run_q;

  assign running  = run_q;
  assign win_end  = run_q & tick & (cnt_q == '0);
  assign last_win = win_end & (left_q == SLOT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      per_q  <= period;
      cnt_q  <= period - PER_W'(1);
      left_q <= slots;
    end else if (stop || last_win) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q == '0) begin
        cnt_q  <= per_q - PER_W'(1);
        left_q <= left_q - SLOT_W'(1);
      end else begin
        cnt_q <= cnt_q - PER_W'(1);
      end
    end
  end

  // R3: the window counter never leaves the latched window
  p_cnt_window_r3: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < per_q));

  // R5: the final window ends the run
  p_last_stops_r5: assert property (@(posedge clk) disable iff (rst)
    (last_win && !start) |=> !run_q);
endmodule

// File: rtl/fgr_gain_ctrl.sv
module fgr_gain_ctrl
  import fgr_pkg::*;
#(
  parameter int GAIN_W = 8,
  parameter int LIM_DEC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fade_out,
  input  logic              fade_in,
  input  logic              lvl_en,
  input  logic [1:0]        step_sel,
  input  logic              zc,
  input  logic              smp_valid,
  input  logic              win_end,
  input  logic              last_win,
  input  logic              lim_req,
  input  logic              host_we,
  input  logic [GAIN_W-1:0] host_gain,
  output logic [GAIN_W-1:0] gain,
  output logic              tmr_start,
  output logic              tmr_stop
);
  fgr_mode_t         mode_q;
  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] preset_q;
  logic [1:0]        step_q;
  logic              fo_q;
  logic              fi_q;
  logic              taken_q;
  logic              lim_pend_q;

  logic              fo_rise;
  logic              fo_fall;
  logic              fi_go;
  logic              fading;
  logic              apply;
  logic              lim_fire;
  logic [GAIN_W-1:0] step_amt;
  logic [GAIN_W-1:0] dn_gain;
  logic [GAIN_W-1:0] up_gain;
  logic [GAIN_W-1:0] lim_gain;
  logic [GAIN_W:0]   up_sum;

  assign fo_rise = fade_out & ~fo_q;
  assign fo_fall = ~fade_out & fo_q & ((mode_q == M_OUT) | (mode_q == M_MUTE));
  assign fi_go   = fade_in & ~fi_q & ~fade_out & (mode_q == M_IDLE);
  assign fading  = (mode_q == M_OUT) | (mode_q == M_IN);

  // one step per window: first crossing, else the closing strobe
  assign apply = fading & ~taken_q & (zc | win_end);

  assign step_amt = GAIN_W'(1) << step_q;
  assign dn_gain  = (gain_q > step_amt) ? (gain_q - step_amt) : '0;
  assign up_sum   = {1'b0, gain_q} + {1'b0, step_amt};
  assign up_gain  = (up_sum > {1'b0, preset_q}) ? preset_q : up_sum[GAIN_W-1:0];
  assign lim_gain = (gain_q > GAIN_W'(LIM_DEC)) ? (gain_q - GAIN_W'(LIM_DEC)) : '0;

  assign lim_fire = lvl_en & lim_pend_q & zc & ~apply & (mode_q != M_MUTE);

  assign tmr_start = fo_rise | fi_go;
  assign tmr_stop  = fo_fall | ((mode_q == M_IN) & ~fade_in);
  assign gain      = gain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fo_q <= 1'b0;
      fi_q <= 1'b0;
    end else begin
      fo_q <= fade_out;
      fi_q <= fade_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q <= '0;
    end else if (host_we) begin
      preset_q <= host_gain;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_pend_q <= 1'b0;
    end else if (lim_fire) begin
      lim_pend_q <= 1'b0;
    end else if (lim_req && lvl_en) begin
      lim_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q <= 1'b0;
    end else if (tmr_start || win_end) begin
      taken_q <= 1'b0;
    end else if (apply) begin
      taken_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_IDLE;
      gain_q <= '0;
      step_q <= '0;
    end else if (fo_rise) begin
      mode_q <= M_OUT;
      step_q <= step_sel;
    end else if (fo_fall) begin
      mode_q <= M_IDLE;
      if (lvl_en) begin
        gain_q <= preset_q;
      end
    end else begin
      unique case (mode_q)
        M_IDLE: begin
          if (fi_go) begin
            mode_q <= M_IN;
            step_q <= step_sel;
          end else if (host_we) begin
            gain_q <= host_gain;
          end else if (lim_fire) begin
            gain_q <= lim_gain;
          end
        end
        M_OUT: begin
          if (last_win) begin
            mode_q <= M_MUTE;
            gain_q <= '0;
          end else if (apply) begin
            gain_q <= dn_gain;
          end else if (lim_fire) begin
            gain_q <= lim_gain;
          end
        end
        M_MUTE: begin
          gain_q <= '0;
        end
        M_IN: begin
          if (!fade_in) begin
            mode_q <= M_IDLE;
          end else if (last_win) begin
            mode_q <= M_IDLE;
            gain_q <= preset_q;
          end else if (apply) begin
            gain_q <= up_gain;
          end else if (lim_fire) begin
            gain_q <= lim_gain;
          end
        end
        default: mode_q <= M_IDLE;
      endcase
    end
  end

  // R6: mute holds while the fade-out request stays up
  p_mute_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_MUTE && fade_out) |=> (gain_q == '0));

  // R3: a running fade-out never raises the gain
  p_fade_monotone_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_OUT && fade_out) |=> (gain_q <= $past(gain_q)));

  // R4: during a fade-out, gain moves only on sample strobes
  p_quiet_between_strobes_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_OUT && fade_out && !smp_valid) |=> $stable(gain_q));

  // R11: a fade-out request always wins
  p_out_priority_r11: assert property (@(posedge clk) disable iff (rst)
    (fade_out && !fo_q) |=> (mode_q == M_OUT));
endmodule

// File: rtl/fade_gain_ramp.sv
module fade_gain_ramp #(
  parameter int GAIN_W    = 8,
  parameter int SMP_W     = 16,
  parameter int PER_BASE  = 4,
  parameter int FADE_SPAN = 96,
  parameter int LIM_DEC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_fade_out,
  input  logic              ctl_fade_in,
  input  logic              ctl_lvl_en,
  input  logic [1:0]        ctl_period,
  input  logic [1:0]        ctl_step,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              lim_req,
  input  logic              host_we,
  input  logic [GAIN_W-1:0] host_gain,
  output logic [GAIN_W-1:0] gain
);
  localparam int PER_W  = $clog2(PER_BASE * 8) + 1;
  localparam int SLOT_W = $clog2(FADE_SPAN + 1);

  logic              zc;
  logic              win_end;
  logic              last_win;
  logic              running;
  logic              tmr_start;
  logic              tmr_stop;
  logic [PER_W-1:0]  per_ticks;
  logic [SLOT_W-1:0] slot_cnt;

  assign per_ticks = PER_W'(PER_BASE) << ctl_period;
  assign slot_cnt  = SLOT_W'(FADE_SPAN) >> ctl_step;

  fgr_zero_cross #(.SMP_W(SMP_W)) u_zc (
    .clk    (clk),
    .rst    (rst),
    .valid  (smp_valid),
    .sample (smp_data),
    .zc     (zc)
  );

  fgr_step_timer #(.PER_W(PER_W), .SLOT_W(SLOT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (tmr_start),
    .stop     (tmr_stop),
    .tick     (smp_valid),
    .period   (per_ticks),
    .slots    (slot_cnt),
    .win_end  (win_end),
    .last_win (last_win),
    .running  (running)
  );

  fgr_gain_ctrl #(.GAIN_W(GAIN_W), .LIM_DEC(LIM_DEC)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fade_out  (ctl_fade_out),
    .fade_in   (ctl_fade_in),
    .lvl_en    (ctl_lvl_en),
    .step_sel  (ctl_step),
    .zc        (zc),
    .smp_valid (smp_valid),
    .win_end   (win_end & running),
    .last_win  (last_win),
    .lim_req   (lim_req),
    .host_we   (host_we),
    .host_gain (host_gain),
    .gain      (gain),
    .tmr_start (tmr_start),
    .tmr_stop  (tmr_stop)
  );
endmodule

// File: tb/fade_gain_ramp_bench.sv
module fade_gain_ramp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_fade_out = 1'b0;
  logic        ctl_fade_in = 1'b0;
  logic        ctl_lvl_en = 1'b0;
  logic [1:0]  ctl_period = 2'd0;
  logic [1:0]  ctl_step = 2'd0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = 16'd0;
  logic        lim_req = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_gain = 8'd0;
  logic [7:0]  gain;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fade_gain_ramp u_fade_gain_ramp (
    .clk(clk), .rst(rst), .ctl_fade_out(ctl_fade_out), .ctl_fade_in(ctl_fade_in),
    .ctl_lvl_en(ctl_lvl_en), .ctl_period(ctl_period), .ctl_step(ctl_step),
    .smp_valid(smp_valid), .smp_data(smp_data), .lim_req(lim_req),
    .host_we(host_we), .host_gain(host_gain), .gain(gain)
  );

  function automatic int exp_down(int g0, int k, int st);
    return (k * st >= g0) ? 0 : g0 - k * st;
  endfunction

  function automatic int win_len(int pf);
    return 4 << pf;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] s);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic strobes(input int n, input logic [15:0] s);
    for (int i = 0; i < n; i++) strobe(s);
  endtask

  task automatic host_write(input int v);
    @(negedge clk);
    host_we = 1'b1;
    host_gain = 8'(v);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_ctl(input logic fo, input logic fi, input logic le);
    @(negedge clk);
    ctl_fade_out = fo;
    ctl_fade_in = fi;
    ctl_lvl_en = le;
    @(negedge clk);
  endtask

  task automatic pulse_lim();
    @(negedge clk);
    lim_req = 1'b1;
    @(negedge clk);
    lim_req = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset gain", gain, 0);

    // R2 idle write
    host_write(100);
    chk("R2 idle host write", gain, 100);

    // R3 / R5: P=4, step 8, constant sign, steps at window ends
    ctl_period = 2'd0; ctl_step = 2'd3;
    set_ctl(1'b1, 1'b0, 1'b0);
    strobes(3, 16'sd1000);
    chk("R4 no step before window end", gain, 100);
    strobe(16'sd1000);
    chk("R3 one window", gain, 92);
    strobes(10 * 4 + 3, 16'sd1000);
    chk("R5 no early mute", gain, 12);
    strobe(16'sd1000);
    chk("R5 mute at 96*P/step", gain, 0);
    strobes(8, 16'sd1000);
    chk("R6 mute holds", gain, 0);
    host_write(77);
    chk("R2 write while muted", gain, 0);
    set_ctl(1'b0, 1'b0, 1'b1);
    chk("R8 preset restore", gain, 77);

    // R4 zero crossings, step 1, then a single limiter action
    set_ctl(1'b0, 1'b0, 1'b0);
    host_write(100);
    ctl_period = 2'd0; ctl_step = 2'd0;
    set_ctl(1'b1, 1'b0, 1'b0);
    strobe(-16'sd500);
    chk("R4 step at crossing", gain, 99);
    strobe(-16'sd400); strobe(-16'sd300); strobe(-16'sd200);
    chk("R4 one step per window", gain, 99);
    strobe(16'sd100);
    chk("R4 step at sign change", gain, 98);
    strobe(16'sd50); strobe(16'sd60); strobe(16'sd70);
    strobe(16'sd0);
    chk("R4 zero sample crossing", gain, 97);
    strobes(3, 16'sd0);
    chk("R4 zeros after step", gain, 97);
    set_ctl(1'b1, 1'b0, 1'b1);
    strobe(16'sd0);
    chk("R4 next window step", gain, 96);
    pulse_lim();
    strobe(16'sd0);
    chk("R7 limiter at crossing", gain, 95);
    strobe(16'sd0); strobe(16'sd0);
    chk("R7 limiter once", gain, 95);
    set_ctl(1'b0, 1'b0, 1'b1);
    chk("R8 preset after mid fade", gain, 100);

    // R9 both drop together
    set_ctl(1'b0, 1'b0, 1'b0);
    host_write(60);
    ctl_period = 2'd1; ctl_step = 2'd1;
    set_ctl(1'b1, 1'b0, 1'b1);
    strobes(16, 16'sd1000);
    chk("R3 P=8 step 2", gain, 56);
    set_ctl(1'b0, 1'b0, 1'b0);
    chk("R9 hold on joint drop", gain, 56);
    strobes(16, 16'sd1000);
    chk("R9 hold stays", gain, 56);

    // R7 total time with limiter, all-zero samples
    host_write(100);
    ctl_period = 2'd0; ctl_step = 2'd3;
    set_ctl(1'b1, 1'b0, 1'b1);
    for (int w = 0; w < 11; w++) begin
      if (w < 3) pulse_lim();
      strobes(4, 16'sd0);
    end
    chk("R7 limiter adds to fade", gain, 9);
    strobes(3, 16'sd0);
    chk("R7 not muted early", gain, 1);
    strobe(16'sd0);
    chk("R7 mute time unchanged", gain, 0);
    set_ctl(1'b0, 1'b0, 1'b0);
    chk("R9 hold at mute", gain, 0);

    // R10 fade-in toward preset 100, step 4, 24 windows
    ctl_period = 2'd0; ctl_step = 2'd2;
    set_ctl(1'b0, 1'b1, 1'b1);
    strobes(4, 16'sd1000);
    chk("R10 first window up", gain, 4);
    strobes(22 * 4, 16'sd1000);
    chk("R10 ramp", gain, 92);
    strobes(4, 16'sd1000);
    chk("R10 reaches preset", gain, 100);

    // R11 both rise together
    set_ctl(1'b0, 1'b0, 1'b1);
    ctl_period = 2'd0; ctl_step = 2'd3;
    set_ctl(1'b1, 1'b1, 1'b1);
    strobes(4, 16'sd1000);
    chk("R11 fade-out wins", gain, 92);
    set_ctl(1'b0, 1'b0, 1'b1);
    chk("R8 restore after R11", gain, 100);

    // R3 / R5 random sweeps
    for (int it = 0; it < 6; it++) begin
      int g0, pf, sf, slots, p, k;
      set_ctl(1'b0, 1'b0, 1'b0);
      g0 = 1 + int'($urandom_range(254));
      pf = int'($urandom_range(3));
      sf = int'($urandom_range(3));
      slots = 96 >> sf;
      p = win_len(pf);
      k = int'($urandom_range(slots - 2));
      host_write(g0);
      ctl_period = 2'(pf); ctl_step = 2'(sf);
      set_ctl(1'b1, 1'b0, 1'b0);
      strobes(k * p, 16'sd1000);
      chk("R3 random partial", gain, exp_down(g0, k, 1 << sf));
      strobes((slots - k) * p - 1, 16'sd1000);
      chk("R5 random before end", gain, exp_down(g0, slots - 1, 1 << sf));
      strobe(16'sd1000);
      chk("R5 random mute", gain, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule